// File: doc/BRIEF.md
# Receive Serial Output Port, System-Timed

This block drives the received frames of one 2.048 Mb/s link onto two serial lines toward the system: a data line and a signaling line. The system supplies the bit clock and the frame pulse; the port only follows them. Each frame holds 256 bit periods split into 32 channels of eight bits. The port fetches each channel's byte and its four signaling bits through a combinational lookup port, then shifts the byte out most significant bit first. The four signaling bits go out on the signaling line during the last four bit times of the same channel.

The bit clock is oversampled by the core clock. Configuration inputs choose which bit-clock edge samples the frame pulse and which edge launches data. A double-rate mode runs the bit clock at twice the data rate, and in that mode a further input picks the first or second data edge of each bit. Other inputs set the frame pulse polarity and a programmable delay, in whole channels plus extra bits, from the frame pulse to the first bit of the frame. A period monitor flags any frame pulse that does not fall on a whole number of frames after the previous one. The flag is sticky and drives an interrupt output that can be masked.

Top module: `rx_sys_serout`

## Requirements
- R1: While reset is held and right after it, ser_data, ser_sig, err_flag and irq are all 0.
- R2: In single-rate mode the output changes only on the data edge, rising when cfg_dat_fall is 0 and falling when it is 1. The k-th data edge counted from the frame start (k = 0 at the first) carries frame bit k mod 256. Frame bit 8c+b is bit (7-b) of channel c's byte.
- R3: When cfg_fp_fall and cfg_dat_fall are equal, bit 0 leaves on the same edge that samples the frame pulse. When they differ, the pulse is ahead and bit 0 leaves on the first data edge after the sampling edge.
- R4: The frame pulse is active when fsync differs from cfg_fp_low, so cfg_fp_low = 1 makes it active low. A frame starts on a sampling edge that sees the pulse active after seeing it inactive on the previous sampling edge.
- R5: With cfg_dbl = 1 each bit spans two bit-clock cycles. Counting data edges from the frame start as j = 0, 1, ..., bit j/2 is launched only on the edges where j mod 2 equals cfg_dbl_second.
- R6: In double-rate mode, a pulse held active over two bit-clock cycles starts the frame at the first of those sampling edges.
- R7: ser_sig is 0 during frame bits 8c+0 to 8c+3. During frame bit 8c+b with b = 4..7 it equals rd_sig[7-b] of channel c, so it stays aligned with the data of the same channel.
- R8: With offset O = 8*cfg_ch_off + cfg_bit_off, the data edge for bit period p after the frame start carries frame bit (p - O) mod 256.
- R9: A frame start other than the first after reset sets err_flag when fewer or more than a whole multiple of 256 bit periods (512 bit-clock cycles in double-rate mode) have passed since the previous frame start. Whole multiples do not set it.
- R10: err_flag stays set until a pulse on err_clr clears it. irq equals err_flag when cfg_irq_en is 1 and is 0 when cfg_irq_en is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock that oversamples the bit clock |
| rst_n | input | 1 | Active-low reset, synchronous to clk |
| bclk | input | 1 | System bit clock |
| fsync | input | 1 | System frame pulse |
| cfg_fp_fall | input | 1 | 1: falling bit-clock edge samples the frame pulse |
| cfg_dat_fall | input | 1 | 1: falling bit-clock edge launches data |
| cfg_dbl | input | 1 | 1: bit clock at twice the data rate |
| cfg_dbl_second | input | 1 | Double-rate mode: 1 launches on the second data edge of each bit |
| cfg_fp_low | input | 1 | 1: frame pulse active low |
| cfg_bit_off | input | 3 | Extra delay in bit periods |
| cfg_ch_off | input | 5 | Delay in whole channels |
| cfg_irq_en | input | 1 | Interrupt enable |
| err_clr | input | 1 | Pulse that clears err_flag |
| rd_ch | output | 5 | Channel whose byte and signaling are needed |
| rd_byte | input | 8 | Data byte of channel rd_ch |
| rd_sig | input | 4 | Signaling bits of channel rd_ch |
| ser_data | output | 1 | Serial data line |
| ser_sig | output | 1 | Serial signaling line |
| err_flag | output | 1 | Sticky frame-pulse period error |
| irq | output | 1 | Masked interrupt |

## Verification
The bench builds the port with its default parameters: a 256-bit frame of eight-bit channels with four signaling bits. This lets the full frame, the wrap at the end of it, and the largest offset of 31 channels plus 7 bits all be observed against real channel contents. The bit clock runs at a quarter of the core clock, so every sampling and data edge falls on a known core cycle. All four combinations of pulse and data edge are used, in both rates. The period monitor is driven with gaps one frame short and one frame long, and with one and two frames exactly.

// File: rtl/rx_sys_serout_pkg.sv
package rx_sys_serout_pkg;

  // Frame bit to emit for a bit-clock position, after the programmable delay.
  function automatic int unsigned frame_index(input int unsigned pos,
                                              input logic        dbl,
                                              input int unsigned off,
                                              input int unsigned frame);
    int unsigned bitn;
    bitn = dbl ? (pos >> 1) : pos;
    return (bitn + frame - (off % frame)) % frame;
  endfunction

  // Last bit-clock position of a frame for the chosen rate.
  function automatic int unsigned frame_last(input logic dbl, input int unsigned frame);
    return dbl ? (2 * frame - 1) : (frame - 1);
  endfunction

endpackage

// File: rtl/rx_sys_serout_edge.sv
module rx_sys_serout_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic bclk,
  input  logic cfg_fp_fall,
  input  logic cfg_dat_fall,
  output logic fp_evt,
  output logic dat_evt
);
  logic bclk_q;
  logic rise, fall;

  always_ff @(posedge clk) begin
    if (!rst_n) bclk_q <= 1'b0;
    else        bclk_q <= bclk;
  end

  assign rise    = bclk & ~bclk_q;
  assign fall    = ~bclk & bclk_q;
  assign fp_evt  = cfg_fp_fall  ? fall : rise;
  assign dat_evt = cfg_dat_fall ? fall : rise;
endmodule

// File: rtl/rx_sys_serout_timer.sv
module rx_sys_serout_timer #(
  parameter int unsigned FRAME_BITS = 256,
  parameter int unsigned POS_W      = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fp_evt,
  input  logic             fp_act,
  input  logic             dbl,
  output logic [POS_W-1:0] pos,
  output logic [POS_W-1:0] pos_nxt,
  output logic             start_evt,
  output logic             period_bad
);
  logic             fp_prev;
  logic             seen;
  logic             wrap;
  logic [POS_W-1:0] last;

  assign last       = POS_W'(rx_sys_serout_pkg::frame_last(dbl, FRAME_BITS));
  assign wrap       = (pos == last);
  assign start_evt  = fp_evt & fp_act & ~fp_prev;
  assign period_bad = start_evt & seen & ~wrap;

  always_comb begin
    pos_nxt = pos;
    if (fp_evt) begin
      if (start_evt || wrap) pos_nxt = '0;
      else                   pos_nxt = pos + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pos     <= '0;
      fp_prev <= 1'b0;
      seen    <= 1'b0;
    end else begin
      pos <= pos_nxt;
      if (fp_evt)    fp_prev <= fp_act;
      if (start_evt) seen    <= 1'b1;
    end
  end
endmodule

// File: rtl/rx_sys_serout_shift.sv
module rx_sys_serout_shift #(
  parameter int unsigned CH_BITS  = 8,
  parameter int unsigned SIG_BITS = 4,
  parameter int unsigned BIT_W    = 3,
  parameter int unsigned SIG_W    = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                upd,
  input  logic [BIT_W-1:0]    bit_in_ch,
  input  logic [CH_BITS-1:0]  rd_byte,
  input  logic [SIG_BITS-1:0] rd_sig,
  output logic                ser_data,
  output logic                ser_sig
);
  localparam logic [BIT_W-1:0] SIG_LIM = BIT_W'(SIG_BITS);

  logic [BIT_W-1:0] rev;
  logic             d_bit, s_bit;

  // Most significant bit first; signaling fills the tail of the channel.
  assign rev   = ~bit_in_ch;
  assign d_bit = rd_byte[rev];
  assign s_bit = (rev < SIG_LIM) ? rd_sig[rev[SIG_W-1:0]] : 1'b0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ser_data <= 1'b0;
      ser_sig  <= 1'b0;
    end else if (upd) begin
      ser_data <= d_bit;
      ser_sig  <= s_bit;
    end
  end
endmodule

// File: rtl/rx_sys_serout.sv
module rx_sys_serout #(
  parameter int unsigned FRAME_BITS = 256,
  parameter int unsigned CH_BITS    = 8,
  parameter int unsigned SIG_BITS   = 4,
  localparam int unsigned IDX_W = $clog2(FRAME_BITS),
  localparam int unsigned BIT_W = $clog2(CH_BITS),
  localparam int unsigned CH_W  = IDX_W - BIT_W,
  localparam int unsigned POS_W = IDX_W + 1,
  localparam int unsigned SIG_W = $clog2(SIG_BITS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bclk,
  input  logic                fsync,
  input  logic                cfg_fp_fall,
  input  logic                cfg_dat_fall,
  input  logic                cfg_dbl,
  input  logic                cfg_dbl_second,
  input  logic                cfg_fp_low,
  input  logic [BIT_W-1:0]    cfg_bit_off,
  input  logic [CH_W-1:0]     cfg_ch_off,
  input  logic                cfg_irq_en,
  input  logic                err_clr,
  output logic [CH_W-1:0]     rd_ch,
  input  logic [CH_BITS-1:0]  rd_byte,
  input  logic [SIG_BITS-1:0] rd_sig,
  output logic                ser_data,
  output logic                ser_sig,
  output logic                err_flag,
  output logic                irq
);
  logic             fp_evt, dat_evt, fp_act;
  logic             start_evt, period_bad, upd;
  logic [POS_W-1:0] pos, pos_nxt;
  logic [IDX_W-1:0] q;

  assign fp_act = fsync ^ cfg_fp_low;

  rx_sys_serout_edge edge_i (
    .clk(clk), .rst_n(rst_n), .bclk(bclk),
    .cfg_fp_fall(cfg_fp_fall), .cfg_dat_fall(cfg_dat_fall),
    .fp_evt(fp_evt), .dat_evt(dat_evt)
  );

  rx_sys_serout_timer #(.FRAME_BITS(FRAME_BITS), .POS_W(POS_W)) timer_i (
    .clk(clk), .rst_n(rst_n), .fp_evt(fp_evt), .fp_act(fp_act), .dbl(cfg_dbl),
    .pos(pos), .pos_nxt(pos_nxt), .start_evt(start_evt), .period_bad(period_bad)
  );

  // Bit index inside the frame after applying channel and bit delay.
  assign q = IDX_W'(rx_sys_serout_pkg::frame_index(32'(pos_nxt), cfg_dbl,
                                                   32'({cfg_ch_off, cfg_bit_off}),
                                                   FRAME_BITS));
  assign rd_ch = q[IDX_W-1:BIT_W];

  // In double-rate mode only one of the two data edges of a bit launches.
  assign upd = dat_evt & (~cfg_dbl | (pos_nxt[0] == cfg_dbl_second));

  rx_sys_serout_shift #(.CH_BITS(CH_BITS), .SIG_BITS(SIG_BITS),
                        .BIT_W(BIT_W), .SIG_W(SIG_W)) shift_i (
    .clk(clk), .rst_n(rst_n), .upd(upd), .bit_in_ch(q[BIT_W-1:0]),
    .rd_byte(rd_byte), .rd_sig(rd_sig), .ser_data(ser_data), .ser_sig(ser_sig)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)          err_flag <= 1'b0;
    else if (period_bad) err_flag <= 1'b1;
    else if (err_clr)    err_flag <= 1'b0;
  end

  assign irq = err_flag & cfg_irq_en;
endmodule

// File: rtl/rx_sys_serout_chk.sv
module rx_sys_serout_chk #(
  parameter int unsigned POS_W = 9
) (
  input logic             clk,
  input logic             rst_n,
  input logic             upd,
  input logic             start_evt,
  input logic             period_bad,
  input logic [POS_W-1:0] pos,
  input logic             err_flag,
  input logic             err_clr,
  input logic             irq,
  input logic             cfg_irq_en,
  input logic             ser_data,
  input logic             ser_sig
);
  AST_HOLD_BETWEEN: assert property (@(posedge clk) disable iff (!rst_n)
    !upd |=> ($stable(ser_data) && $stable(ser_sig))); // R2

  AST_START_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> (pos == '0)); // R3

  AST_ERR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_flag) |-> $past(period_bad)); // R9

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (err_flag && !err_clr) |=> err_flag); // R10

  AST_IRQ_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_irq_en |-> !irq); // R10
endmodule

bind rx_sys_serout rx_sys_serout_chk #(.POS_W(POS_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .upd(upd), .start_evt(start_evt),
  .period_bad(period_bad), .pos(pos), .err_flag(err_flag), .err_clr(err_clr),
  .irq(irq), .cfg_irq_en(cfg_irq_en), .ser_data(ser_data), .ser_sig(ser_sig)
);

// File: tb/rx_sys_serout_tb_top.sv
module rx_sys_serout_tb_top;
  logic       clk = 1'b0;
  logic       rst_n, bclk, fsync;
  logic       cfg_fp_fall, cfg_dat_fall, cfg_dbl, cfg_dbl_second, cfg_fp_low;
  logic [2:0] cfg_bit_off;
  logic [4:0] cfg_ch_off;
  logic       cfg_irq_en, err_clr;
  logic [4:0] rd_ch;
  logic [7:0] rd_byte;
  logic [3:0] rd_sig;
  logic       ser_data, ser_sig, err_flag, irq;

  int  nvec  = 0;
  int  nfail = 0;
  bit  done  = 0;

  always #10 clk = ~clk;

  function automatic logic [7:0] byte_of(input int ch);
    return 8'((ch * 53 + 17) ^ (ch << 3));
  endfunction
  function automatic logic [3:0] sig_of(input int ch);
    return 4'(ch * 7 + 3);
  endfunction

  assign rd_byte = byte_of(int'(rd_ch));
  assign rd_sig  = sig_of(int'(rd_ch));

  rx_sys_serout dut_i (
    .clk(clk), .rst_n(rst_n), .bclk(bclk), .fsync(fsync),
    .cfg_fp_fall(cfg_fp_fall), .cfg_dat_fall(cfg_dat_fall), .cfg_dbl(cfg_dbl),
    .cfg_dbl_second(cfg_dbl_second), .cfg_fp_low(cfg_fp_low),
    .cfg_bit_off(cfg_bit_off), .cfg_ch_off(cfg_ch_off), .cfg_irq_en(cfg_irq_en),
    .err_clr(err_clr), .rd_ch(rd_ch), .rd_byte(rd_byte), .rd_sig(rd_sig),
    .ser_data(ser_data), .ser_sig(ser_sig), .err_flag(err_flag), .irq(irq)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nvec++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic setup(input logic fpf, input logic datf, input logic dbl,
                       input logic sec, input logic low, input int choff, input int boff);
    cfg_fp_fall = fpf; cfg_dat_fall = datf; cfg_dbl = dbl; cfg_dbl_second = sec;
    cfg_fp_low = low; cfg_ch_off = 5'(choff); cfg_bit_off = 3'(boff);
    fsync = low;
  endtask

  // One bit-clock cycle: rising half then falling half, two core cycles each.
  task automatic bcycle(input logic fs);
    bclk = 1'b1; fsync = fs; @(negedge clk); @(negedge clk);
    bclk = 1'b0;             @(negedge clk); @(negedge clk);
  endtask

  // Pulse at cycle 0 (held for 'hold' cycles); compare every launched bit.
  task automatic run_stream(input string tag, input int ncyc, input int hold);
    int  o, j, p, qq, ch, b;
    bit  synced;
    logic act, inact, e_fall, exp_d, exp_s;
    logic [7:0] by;
    logic [3:0] sg;
    o = (int'(cfg_ch_off) * 8 + int'(cfg_bit_off)) % 256;
    act = ~cfg_fp_low; inact = cfg_fp_low;
    synced = 0; j = 0;
    for (int c = 0; c < ncyc; c++) begin
      for (int h = 0; h < 2; h++) begin
        bclk  = (h == 0);
        fsync = (c < hold) ? act : inact;
        @(negedge clk);
        e_fall = (h == 1);
        if (e_fall == cfg_fp_fall && c == 0) begin synced = 1; j = 0; end
        if (e_fall == cfg_dat_fall && synced) begin
          if (!cfg_dbl || (j % 2) == int'(cfg_dbl_second)) begin
            p  = (j >> int'(cfg_dbl)) % 256;
            qq = (p - o + 256) % 256;
            ch = qq / 8; b = qq % 8;
            by = byte_of(ch); sg = sig_of(ch);
            exp_d = by[7 - b];
            exp_s = (b >= 4) ? sg[7 - b] : 1'b0;
            check({tag, " data"}, 32'(ser_data), 32'(exp_d));
            check({tag, " sig R7"}, 32'(ser_sig), 32'(exp_s));
          end
          j++;
        end
        @(negedge clk);
      end
    end
  endtask

  task automatic clear_err();
    err_clr = 1'b1; @(negedge clk); err_clr = 1'b0; @(negedge clk);
  endtask

  // Two frame starts 'gap' bit-clock cycles apart.
  task automatic gap_test(input string tag, input int gap, input logic exp_err);
    logic act, inact;
    act = ~cfg_fp_low; inact = cfg_fp_low;
    bcycle(act);
    clear_err();
    repeat (gap - 1) bcycle(inact);
    bcycle(act);
    repeat (2) bcycle(inact);
    check({tag, " err_flag"}, 32'(err_flag), 32'(exp_err));
    check({tag, " irq R10"}, 32'(irq), 32'(exp_err & cfg_irq_en));
  endtask

  task automatic t_reset();
    rst_n = 1'b0; bclk = 1'b0; err_clr = 1'b0; cfg_irq_en = 1'b0;
    setup(0, 0, 0, 0, 0, 0, 0);
    repeat (3) @(negedge clk);
    check("R1 ser_data in reset", 32'(ser_data), 0);
    check("R1 ser_sig in reset",  32'(ser_sig), 0);
    check("R1 err_flag in reset", 32'(err_flag), 0);
    check("R1 irq in reset",      32'(irq), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R1 ser_data after reset", 32'(ser_data), 0);
    check("R1 err_flag after reset", 32'(err_flag), 0);
  endtask

  task automatic t_irq();
    cfg_irq_en = 1'b1;
    setup(0, 0, 0, 0, 0, 0, 0);
    gap_test("R9 R10 gap 255 irq on", 255, 1'b1);
    clear_err();
    check("R10 err cleared", 32'(err_flag), 0);
    check("R10 irq cleared", 32'(irq), 0);
    gap_test("R9 gap 257", 257, 1'b1);
    repeat (3) @(negedge clk);
    check("R10 err sticky", 32'(err_flag), 1);
    cfg_irq_en = 1'b0;
    @(negedge clk);
    check("R10 irq masked", 32'(irq), 0);
    check("R10 err kept while masked", 32'(err_flag), 1);
  endtask

  initial begin
    t_reset();
    setup(0, 0, 0, 0, 0, 0, 0); run_stream("R2 R3 1x rise/rise", 260, 1);
    setup(1, 0, 0, 0, 0, 0, 0); run_stream("R3 1x fp fall data rise", 260, 1);
    setup(0, 1, 0, 0, 0, 0, 0); run_stream("R2 R3 1x fp rise data fall", 260, 1);
    setup(1, 1, 0, 0, 0, 0, 0); run_stream("R2 1x fall/fall", 260, 1);
    setup(0, 0, 1, 0, 0, 0, 0); run_stream("R5 2x first edge", 520, 1);
    setup(1, 0, 1, 1, 0, 0, 0); run_stream("R5 2x second edge fp ahead", 520, 1);
    setup(0, 0, 1, 1, 0, 0, 0); run_stream("R6 2x pulse held two cycles", 520, 2);
    setup(0, 0, 0, 0, 1, 0, 0); run_stream("R4 active-low pulse", 260, 1);
    setup(0, 0, 0, 0, 0, 3, 5); run_stream("R8 offset 3ch+5b", 260, 1);
    setup(1, 0, 0, 0, 0, 31, 7); run_stream("R8 offset 31ch+7b", 260, 1);
    setup(0, 0, 0, 0, 0, 0, 0);
    gap_test("R9 gap 256", 256, 1'b0);
    gap_test("R9 gap 512", 512, 1'b0);
    gap_test("R9 gap 255", 255, 1'b1);
    setup(0, 0, 1, 0, 0, 0, 0);
    gap_test("R9 2x gap 512", 512, 1'b0);
    gap_test("R9 2x gap 256", 256, 1'b1);
    t_irq();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
    end
  end
endmodule